// File: doc/BRIEF.md
# Toggle-Bit Completion Poller for Parallel NOR Flash

This block decides when an embedded program or erase operation inside a parallel NOR flash has finished. After a controller has issued the command sequence, it pulses `start` and says with `isErase` which kind of operation is running. The poller then reads the flash status byte again and again through a simple one-request, one-response read port. It watches the toggle bit (bit 6), which flips on every read while the flash is busy and holds still once the operation is over.

Each attempt takes a pair of back-to-back reads. A matching toggle bit means the operation is complete. A flipping toggle bit together with the timeout flag (bit 5) in the second read triggers one extra pair of reads as a recheck. If the toggle bit still flips, the block waits before the next attempt: longer for an erase, shorter for a program. After a fixed number of attempts it gives up. The outcome is reported as a one-cycle `done` pulse and a `pass` level that holds until the next start.

Top module: `togglePoller`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `rdReq` are all 0.
- R2: A `start` pulse while idle begins an attempt, and each attempt starts with two status reads. A `start` while busy is ignored and does not change the latched operation kind.
- R3: When bit 6 (mask 0x40) of the two reads of a pair is equal, the poller finishes with `pass`=1 without any retry delay. All bits other than 6 and 5 have no effect.
- R4: When bit 6 differs across the first pair and bit 5 (mask 0x20) of the second read is 1, exactly two more reads are made. If bit 6 matches across them, the result is `pass`=1 with no delay.
- R5: When the recheck pair still shows bit 6 flipping, no failure is declared: the block waits and starts a new attempt. Bit 5 in a recheck pair never starts another recheck.
- R6: Bit 5 set only in the first read of a pair does not start a recheck.
- R7: The wait between attempts is CLK_MHZ*ERASE_US cycles for an erase and CLK_MHZ*PROG_US cycles for a program.
- R8: After MAX_TRIES attempts that all end in a wait, the poller finishes with `pass`=0.
- R9: `done` is high for exactly one cycle per operation. `pass` holds its value until the next accepted `start`, which clears it.
- R10: `rdReq` is a single-cycle pulse, and no new request is issued before `rdValid` has returned the previous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin polling (taken only when idle) |
| isErase | input | 1 | 1 = erase in progress, 0 = program |
| rdReq | output | 1 | Status read request pulse |
| rdValid | input | 1 | Read data returned this cycle |
| rdData | input | DATA_W | Status byte from the flash base address |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last operation, held until next start |

## Verification
The bench builds the poller with CLK_MHZ=1 and MAX_TRIES=4. This gives 25-cycle program waits and 50-cycle erase waits, so the two delay classes separate clearly by elapsed cycles. It also lets a run of never-settling status reach the give-up path within a few hundred cycles. A status model with a two-cycle read latency replays toggle sequences for every combination of bit-5 placement, recheck outcome and operation kind. Read counts and elapsed cycles are compared against values derived arithmetically from these parameters.

// File: rtl/pollPkg.sv
package pollPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ_A,
    S_WAIT_A,
    S_REQ_B,
    S_WAIT_B,
    S_EVAL,
    S_DELAY
  } pollStateT;

  typedef struct packed {
    logic latchMode;
    logic capA;
    logic capB;
    logic loadDelay;
    logic countDown;
    logic clrTry;
    logic incTry;
  } pollStrobeT;

endpackage

// File: rtl/pollDatapath.sv
module pollDatapath
  import pollPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TOGGLE_BIT  = 6,
  parameter int TIMEOUT_BIT = 5,
  parameter int ERASE_CYC   = 50,
  parameter int PROG_CYC    = 25,
  parameter int MAX_TRIES   = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobeT        strobe,
  input  logic              isErase,
  input  logic [DATA_W-1:0] rdData,
  output logic              toggled,
  output logic              timeoutFlag,
  output logic              delayZero,
  output logic              lastTry
);

  localparam int LONG_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int DLY_W    = $clog2(LONG_CYC + 1);
  localparam int TRY_W    = $clog2(MAX_TRIES + 1);
  localparam logic [DATA_W-1:0] TOGGLE_MASK  = DATA_W'(1) << TOGGLE_BIT;
  localparam logic [DATA_W-1:0] TIMEOUT_MASK = DATA_W'(1) << TIMEOUT_BIT;
  localparam logic [DLY_W-1:0]  ERASE_LOAD   = DLY_W'(ERASE_CYC - 1);
  localparam logic [DLY_W-1:0]  PROG_LOAD    = DLY_W'(PROG_CYC - 1);
  localparam logic [TRY_W-1:0]  LAST_TRY     = TRY_W'(MAX_TRIES - 1);

  logic [DATA_W-1:0] byteA;
  logic [DATA_W-1:0] byteB;
  logic              eraseQ;
  logic [DLY_W-1:0]  delayCnt;
  logic [TRY_W-1:0]  tryCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteA  <= '0;
      byteB  <= '0;
      eraseQ <= 1'b0;
    end else begin
      if (strobe.latchMode) eraseQ <= isErase;
      if (strobe.capA)      byteA  <= rdData;
      if (strobe.capB)      byteB  <= rdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayCnt <= '0;
    end else if (strobe.loadDelay) begin
      delayCnt <= eraseQ ? ERASE_LOAD : PROG_LOAD;
    end else if (strobe.countDown && delayCnt != '0) begin
      delayCnt <= delayCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tryCnt <= '0;
    end else if (strobe.clrTry) begin
      tryCnt <= '0;
    end else if (strobe.incTry) begin
      tryCnt <= tryCnt + 1'b1;
    end
  end

  assign toggled     = |((byteA ^ byteB) & TOGGLE_MASK);
  assign timeoutFlag = |(byteB & TIMEOUT_MASK);
  assign delayZero   = (delayCnt == '0);
  assign lastTry     = (tryCnt == LAST_TRY);

endmodule

// File: rtl/pollControl.sv
module pollControl
  import pollPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rdValid,
  input  logic       toggled,
  input  logic       timeoutFlag,
  input  logic       delayZero,
  input  logic       lastTry,
  output pollStrobeT strobe,
  output logic       rdReq,
  output logic       busy,
  output logic       done,
  output logic       pass
);

  pollStateT state, nextState;
  logic recheckQ;
  logic setRecheck, clrRecheck;
  logic finish, finishPass, clearPass;

  always_comb begin
    nextState  = state;
    strobe     = '0;
    setRecheck = 1'b0;
    clrRecheck = 1'b0;
    finish     = 1'b0;
    finishPass = 1'b0;
    clearPass  = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strobe.latchMode = 1'b1;
          strobe.clrTry    = 1'b1;
          clrRecheck       = 1'b1;
          clearPass        = 1'b1;
          nextState        = S_REQ_A;
        end
      end
      S_REQ_A: nextState = S_WAIT_A;
      S_WAIT_A: begin
        if (rdValid) begin
          strobe.capA = 1'b1;
          nextState   = S_REQ_B;
        end
      end
      S_REQ_B: nextState = S_WAIT_B;
      S_WAIT_B: begin
        if (rdValid) begin
          strobe.capB = 1'b1;
          nextState   = S_EVAL;
        end
      end
      S_EVAL: begin
        if (!toggled) begin
          finish     = 1'b1;
          finishPass = 1'b1;
          nextState  = S_IDLE;
        end else if (!recheckQ && timeoutFlag) begin
          setRecheck = 1'b1;
          nextState  = S_REQ_A;
        end else begin
          strobe.loadDelay = 1'b1;
          clrRecheck       = 1'b1;
          nextState        = S_DELAY;
        end
      end
      S_DELAY: begin
        if (delayZero) begin
          strobe.incTry = 1'b1;
          if (lastTry) begin
            finish    = 1'b1;
            nextState = S_IDLE;
          end else begin
            nextState = S_REQ_A;
          end
        end else begin
          strobe.countDown = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      recheckQ <= 1'b0;
      done     <= 1'b0;
      pass     <= 1'b0;
    end else begin
      state <= nextState;
      done  <= finish;
      if (setRecheck)      recheckQ <= 1'b1;
      else if (clrRecheck) recheckQ <= 1'b0;
      if (clearPass)       pass <= 1'b0;
      else if (finish)     pass <= finishPass;
    end
  end

  assign rdReq = (state == S_REQ_A) || (state == S_REQ_B);
  assign busy  = (state != S_IDLE);

endmodule

// File: rtl/togglePoller.sv
module togglePoller
  import pollPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TOGGLE_BIT  = 6,
  parameter int TIMEOUT_BIT = 5,
  parameter int CLK_MHZ     = 200,
  parameter int ERASE_US    = 50,
  parameter int PROG_US     = 25,
  parameter int MAX_TRIES   = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isErase,
  output logic              rdReq,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              pass
);

  localparam int ERASE_CYC = CLK_MHZ * ERASE_US;
  localparam int PROG_CYC  = CLK_MHZ * PROG_US;

  pollStrobeT strobe;
  logic toggled, timeoutFlag, delayZero, lastTry;

  pollControl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .rdValid    (rdValid),
    .toggled    (toggled),
    .timeoutFlag(timeoutFlag),
    .delayZero  (delayZero),
    .lastTry    (lastTry),
    .strobe     (strobe),
    .rdReq      (rdReq),
    .busy       (busy),
    .done       (done),
    .pass       (pass)
  );

  pollDatapath #(
    .DATA_W     (DATA_W),
    .TOGGLE_BIT (TOGGLE_BIT),
    .TIMEOUT_BIT(TIMEOUT_BIT),
    .ERASE_CYC  (ERASE_CYC),
    .PROG_CYC   (PROG_CYC),
    .MAX_TRIES  (MAX_TRIES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .isErase    (isErase),
    .rdData     (rdData),
    .toggled    (toggled),
    .timeoutFlag(timeoutFlag),
    .delayZero  (delayZero),
    .lastTry    (lastTry)
  );

endmodule

// File: rtl/togglePollerChecker.sv
module togglePollerChecker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic rdReq,
  input logic rdValid,
  input logic busy,
  input logic done,
  input logic pass
);

  logic pending;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pending <= 1'b0;
    else if (rdReq)   pending <= 1'b1;
    else if (rdValid) pending <= 1'b0;
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  assert_pass_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(pass));

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !pass));

  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> !pending);

  assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> busy);

endmodule

bind togglePoller togglePollerChecker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .rdReq  (rdReq),
  .rdValid(rdValid),
  .busy   (busy),
  .done   (done),
  .pass   (pass)
);

// File: tb/togglePoller_tb.sv
module togglePoller_tb;

  localparam int CLK_MHZ   = 1;
  localparam int ERASE_US  = 50;
  localparam int PROG_US   = 25;
  localparam int MAX_TRIES = 4;
  localparam int E_CYC     = CLK_MHZ * ERASE_US;
  localparam int P_CYC     = CLK_MHZ * PROG_US;
  localparam int SLACK     = 40;
  localparam int FOREVER_T = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic isErase = 1'b0;
  logic rdReq, rdValid, busy, done, pass;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  togglePoller #(
    .CLK_MHZ  (CLK_MHZ),
    .ERASE_US (ERASE_US),
    .PROG_US  (PROG_US),
    .MAX_TRIES(MAX_TRIES)
  ) u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .isErase(isErase),
    .rdReq  (rdReq),
    .rdValid(rdValid),
    .rdData (rdData),
    .busy   (busy),
    .done   (done),
    .pass   (pass)
  );

  // Status model: two-cycle read latency
  int readIdx = 0;
  int baseIdx = 0;
  int toggleReads = 0;
  int dq5Mode = 0;   // 0 none, 1 every toggling read, 2 first read of pair only
  logic reqD = 1'b0;
  int reqViol = 0;
  bit outstanding = 1'b0;

  function automatic logic [7:0] statusByte(int rel);
    logic [7:0] b;
    b = 8'((rel * 37 + 11)) & 8'h9F;
    if (rel < toggleReads) begin
      b[6] = rel[0];
      if (dq5Mode == 1) b[5] = 1'b1;
      if (dq5Mode == 2) b[5] = ~rel[0];
    end else begin
      b[6] = 1'b1;
    end
    return b;
  endfunction

  always @(posedge clk) begin
    reqD    <= rdReq;
    rdValid <= reqD;
    if (reqD) begin
      rdData  <= statusByte(readIdx - baseIdx);
      readIdx <= readIdx + 1;
    end
  end

  // R10 monitor: no request while one is outstanding
  always @(negedge clk) begin
    if (rdReq && outstanding) reqViol++;
    if (rdReq) outstanding = 1'b1;
    else if (rdValid) outstanding = 1'b0;
  end

  task automatic check(bit ok, string tag, int actual, int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // Run one operation; returns reads, cycles from start to done, and result
  task automatic runOp(input bit erase, input int tReads, input int dMode,
                       input bit midStart,
                       output int reads, output int cycles, output bit res);
    @(negedge clk);
    toggleReads = tReads;
    dq5Mode     = dMode;
    baseIdx     = readIdx;
    isErase     = erase;
    start       = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    isErase = 1'b0;
    cycles  = 1;
    while (!done && cycles < 5000) begin
      if (midStart && cycles == 3) begin
        start   = 1'b1;
        isErase = 1'b1;
      end else begin
        start   = 1'b0;
        isErase = 1'b0;
      end
      @(negedge clk);
      cycles++;
    end
    start = 1'b0;
    reads = readIdx - baseIdx;
    res   = pass;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int r, c;
    bit p;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && done == 0 && pass == 0 && rdReq == 0, "R1 reset outputs", {busy, done, pass, rdReq}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && rdReq == 0, "R1 idle after reset", {busy, rdReq}, 0);

    // R3: immediately stable, noise bits ignored, no delay
    runOp(1'b0, 0, 0, 1'b0, r, c, p);
    check(p == 1, "R3 stable pass", p, 1);
    check(r == 2, "R2 two reads per attempt", r, 2);
    check(c < P_CYC, "R3 no delay", c, P_CYC);

    // R9: done one cycle, pass held
    @(negedge clk);
    check(done == 0, "R9 done single cycle", done, 0);
    repeat (10) @(negedge clk);
    check(pass == 1, "R9 pass held", pass, 1);

    // R7: program, two toggling attempts
    runOp(1'b0, 4, 0, 1'b0, r, c, p);
    check(p == 1 && r == 6, "R7 program pass reads", r, 6);
    check(c >= 2 * P_CYC && c <= 2 * P_CYC + SLACK, "R7 program delay", c, 2 * P_CYC);

    // R7: erase, same pattern
    runOp(1'b1, 4, 0, 1'b0, r, c, p);
    check(p == 1 && r == 6, "R7 erase pass reads", r, 6);
    check(c >= 2 * E_CYC && c <= 2 * E_CYC + SLACK, "R7 erase delay", c, 2 * E_CYC);

    // R8: never settles, no timeout flag
    runOp(1'b0, FOREVER_T, 0, 1'b0, r, c, p);
    check(p == 0, "R8 fail result", p, 0);
    check(r == 2 * MAX_TRIES, "R8 attempt count", r, 2 * MAX_TRIES);
    check(c >= MAX_TRIES * P_CYC, "R8 waits between attempts", c, MAX_TRIES * P_CYC);

    // R9: pass cleared by start (previous result 0 -> make it 1 first)
    runOp(1'b0, 0, 0, 1'b0, r, c, p);
    @(negedge clk);
    start = 1'b1;
    toggleReads = 0; dq5Mode = 0; baseIdx = readIdx;
    @(negedge clk);
    start = 1'b0;
    check(pass == 0 && busy == 1, "R9 start clears pass", pass, 0);
    while (!done) @(negedge clk);

    // R4: timeout flag, recheck settles
    runOp(1'b0, 2, 1, 1'b0, r, c, p);
    check(p == 1 && r == 4, "R4 recheck reads", r, 4);
    check(c < P_CYC, "R4 recheck without delay", c, P_CYC);

    // R5: recheck still toggling, continue after delay
    runOp(1'b0, 4, 1, 1'b0, r, c, p);
    check(p == 1 && r == 6, "R5 continue after recheck", r, 6);
    check(c >= P_CYC, "R5 delay after recheck", c, P_CYC);

    // R5/R8: timeout flag forever -> one recheck per attempt, then fail
    runOp(1'b0, FOREVER_T, 1, 1'b0, r, c, p);
    check(p == 0, "R5 fail after rechecks", p, 0);
    check(r == 4 * MAX_TRIES, "R5 single recheck per attempt", r, 4 * MAX_TRIES);

    // R6: flag only in first read of pair
    runOp(1'b0, 2, 2, 1'b0, r, c, p);
    check(p == 1 && r == 4, "R6 reads", r, 4);
    check(c >= P_CYC, "R6 no recheck, delay taken", c, P_CYC);

    // R2: start while busy ignored (mode not relatched to erase)
    runOp(1'b0, 2, 0, 1'b1, r, c, p);
    check(p == 1 && r == 4, "R2 busy start reads", r, 4);
    check(c >= P_CYC && c <= P_CYC + SLACK, "R2 busy start keeps program delay", c, P_CYC);

    // R10: request discipline
    check(reqViol == 0, "R10 one outstanding read", reqViol, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule